// File: doc/BRIEF.md
# Link Physical Trailer Appender

This block sits on an input link card between a received byte stream and the stream it forwards. Each event in the stream opens with a start marker and closes with an end marker. The block forwards the event's bytes without changing them. While it does so, it keeps a running 8-bit XOR of every data byte. It also records whether the receive-error strobe was raised on any of those bytes. When the end marker arrives, the block holds it back and first emits a short physical trailer made from that state. The end marker follows the trailer. The trailer is placed after any logical trailer and zero padding, so it deliberately breaks the event's 16-byte grouping.

A parameter selects one of two trailer variants. The short variant adds two bytes: the parity byte, then a status byte. The wide variant builds a 16-byte trailer. It keeps back the last two data bytes of the event, which are the physical trailer written by an upstream card. It places them at the head of its own trailer and adds its own parity and status bytes at the tail. The status byte holds an error flag in bit 7 and a 2-bit card-type code in bits 1:0. The status byte is never counted in the parity.

Both stream sides use valid/ready handshaking. A beat moves when valid and ready are both high at a rising clock edge. While `out_valid` is high and `out_ready` is low, the output beat stays the same. The upstream source must likewise hold each input beat until it is accepted. The input is stalled (`in_ready` low) while trailer bytes are emitted.

Top module: `link_trailer_appender`

## Requirements
- R1: Beat kinds are encoded as 0 = data, 1 = start marker, 2 = end marker. In the short variant (`WIDE`=0), every start marker and data byte leaves unchanged, in arrival order, with its kind preserved.
- R2: Trailer bytes are sent as kind 0, straight after the event's last forwarded data byte. The end marker comes right after the trailer. The trailer is 2 bytes long when `WIDE`=0 and 16 bytes long when `WIDE`=1.
- R3: The parity trailer byte is the XOR of all data bytes accepted since the last start marker, and is 0 for an event with no data bytes. It is byte 0 of the short trailer and byte 14 of the wide trailer.
- R4: The status trailer byte is the last byte of either trailer. Bit 7 is the OR of `in_rx_err` over the event's accepted data beats, bits 6:2 are 0, and bits 1:0 equal `CARD_ID`. The status byte never contributes to any parity.
- R5: An accepted start marker clears both the parity and the error flag. The value of `in_rx_err` on a start-marker or end-marker beat has no effect on any trailer.
- R6: `in_ready` is low from the cycle an unsent end marker is presented until the last trailer byte is accepted. With `out_ready` held high, the end marker waits exactly trailer-length + 1 cycles.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_kind` stay unchanged in the next cycle, provided the source holds its beat.
- R8: When `WIDE`=1, the last two data bytes of an event are not forwarded as data. Trailer bytes 0 and 1 carry them: byte 0 is the second-to-last byte and byte 1 is the last byte, with 0 filling any missing byte. Bytes 2 to 13 are 0, and the parity in byte 14 covers all data bytes, these two included.
- R9: After reset, `out_valid` is low and the parity and error flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_kind | input | 2 | Input beat kind: 0 data, 1 start, 2 end |
| in_data | input | DW | Input byte |
| in_rx_err | input | 1 | Receive-error strobe for this input byte |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_kind | output | 2 | Output beat kind |
| out_data | output | DW | Output byte |

## Verification
Events are driven with zero, one, two and many data bytes, so the wide variant's zero-filling of missing held bytes is told apart from a real hold. One event raises the error strobe on a single middle byte, which separates OR-accumulation from taking the last strobe. The next event raises the strobe only on its start marker, right after an errored event, which shows that the start marker clears the flag and that its own strobe is ignored. Free-flowing runs measure how long the end marker stalls. Runs with random back-pressure show that trailer bytes and held wide-mode bytes are neither lost nor repeated when the output stalls in the middle of a sequence.

// File: rtl/lta_pkg.sv
package lta_pkg;
  typedef enum logic [1:0] {
    K_DATA = 2'd0,
    K_SOE  = 2'd1,
    K_EOE  = 2'd2,
    K_RSV  = 2'd3
  } kind_e;

  typedef enum logic {
    ST_PASS  = 1'b0,
    ST_TRAIL = 1'b1
  } st_e;
endpackage

// File: rtl/lta_accum.sv
// Running XOR parity and sticky receive-error flag for one event.
module lta_accum #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          add,
  input  logic [DW-1:0] din,
  input  logic          err_in,
  output logic [DW-1:0] par,
  output logic          err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par <= '0;
      err <= 1'b0;
    end else if (clear) begin
      par <= '0;
      err <= 1'b0;
    end else if (add) begin
      par <= par ^ din;
      err <= err | err_in;
    end
  end
endmodule

// File: rtl/lta_hold.sv
// Two-deep hold-back of the newest data bytes (wide variant only).
module lta_hold #(
  parameter int DW     = 8,
  parameter bit ENABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic [DW-1:0] older,
  output logic [DW-1:0] newer
);
  generate
    if (ENABLE) begin : g_hold
      logic [1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt   <= '0;
          older <= '0;
          newer <= '0;
        end else if (clear) begin
          cnt   <= '0;
          older <= '0;
          newer <= '0;
        end else if (push) begin
          older <= newer;
          newer <= din;
          if (cnt != 2'd2) cnt <= cnt + 2'd1;
        end
      end
      assign full = (cnt == 2'd2);
    end else begin : g_none
      logic unused_hold;
      assign unused_hold = ^{clk, rst_n, clear, push, din};
      assign full  = 1'b1;
      assign older = '0;
      assign newer = '0;
    end
  endgenerate
endmodule

// File: rtl/lta_trailer_sel.sv
// Picks the trailer byte for the current trailer index.
module lta_trailer_sel #(
  parameter int         DW      = 8,
  parameter int         TRL_LEN = 2,
  parameter int         IDX_W   = 1,
  parameter bit         WIDE    = 1'b0,
  parameter logic [1:0] CARD_ID = 2'd0
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    par,
  input  logic             err,
  input  logic [DW-1:0]    older,
  input  logic [DW-1:0]    newer,
  output logic [DW-1:0]    byte_o
);
  localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(TRL_LEN - 2);
  localparam logic [IDX_W-1:0] STS_IDX = IDX_W'(TRL_LEN - 1);

  logic [DW-1:0] sts;
  always_comb begin
    sts       = '0;
    sts[DW-1] = err;
    sts[1:0]  = CARD_ID;
  end

  generate
    if (WIDE) begin : g_wide
      always_comb begin
        if (idx == IDX_W'(0))      byte_o = older;
        else if (idx == IDX_W'(1)) byte_o = newer;
        else if (idx == PAR_IDX)   byte_o = par;
        else if (idx == STS_IDX)   byte_o = sts;
        else                       byte_o = '0;
      end
    end else begin : g_short
      logic unused_sel;
      assign unused_sel = ^{older, newer};
      assign byte_o = (idx == PAR_IDX) ? par : sts;
    end
  endgenerate
endmodule

// File: rtl/link_trailer_appender.sv
module link_trailer_appender
  import lta_pkg::*;
#(
  parameter int         DW      = 8,
  parameter bit         WIDE    = 1'b0,
  parameter logic [1:0] CARD_ID = 2'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic [DW-1:0] in_data,
  input  logic          in_rx_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [DW-1:0] out_data
);
  localparam int TRL_LEN = WIDE ? 16 : 2;
  localparam int IDX_W   = $clog2(TRL_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TRL_LEN - 1);

  st_e              st;
  logic [IDX_W-1:0] idx;
  logic             trl_done;
  kind_e            kin;
  logic             in_fire, data_fire, soe_fire, eoe_fire, trl_last_fire;
  logic             in_trl;
  logic [DW-1:0]    acc_par;
  logic             acc_err;
  logic             hold_full;
  logic [DW-1:0]    hold_old, hold_new, trl_byte, fwd_byte;

  assign kin           = kind_e'(in_kind);
  assign in_trl        = (st == ST_TRAIL);
  assign in_fire       = in_valid && in_ready;
  assign data_fire     = in_fire && (kin == K_DATA);
  assign soe_fire      = in_fire && (kin == K_SOE);
  assign eoe_fire      = in_fire && (kin == K_EOE);
  assign trl_last_fire = in_trl && out_ready && (idx == LAST_IDX);
  assign fwd_byte      = WIDE ? hold_old : in_data;

  lta_accum #(.DW(DW)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(soe_fire), .add(data_fire),
    .din(in_data), .err_in(in_rx_err), .par(acc_par), .err(acc_err)
  );

  lta_hold #(.DW(DW), .ENABLE(WIDE)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(soe_fire || trl_last_fire),
    .push(data_fire), .din(in_data), .full(hold_full),
    .older(hold_old), .newer(hold_new)
  );

  lta_trailer_sel #(
    .DW(DW), .TRL_LEN(TRL_LEN), .IDX_W(IDX_W), .WIDE(WIDE), .CARD_ID(CARD_ID)
  ) u_sel (
    .idx(idx), .par(acc_par), .err(acc_err), .older(hold_old),
    .newer(hold_new), .byte_o(trl_byte)
  );

  always_comb begin
    out_valid = 1'b0;
    in_ready  = 1'b0;
    out_kind  = in_kind;
    out_data  = in_data;
    if (in_trl) begin
      out_valid = 1'b1;
      out_kind  = K_DATA;
      out_data  = trl_byte;
    end else if (in_valid && (kin == K_EOE) && !trl_done) begin
      // end marker waits until the trailer has been sent
    end else if ((kin == K_DATA) && !hold_full) begin
      in_ready = 1'b1;
    end else begin
      out_valid = in_valid;
      in_ready  = out_ready;
      if (kin == K_DATA) out_data = fwd_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_PASS;
      idx      <= '0;
      trl_done <= 1'b0;
    end else begin
      if (!in_trl && in_valid && (kin == K_EOE) && !trl_done) begin
        st  <= ST_TRAIL;
        idx <= '0;
      end else if (in_trl && out_ready) begin
        if (idx == LAST_IDX) begin
          st       <= ST_PASS;
          trl_done <= 1'b1;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
      if (eoe_fire) trl_done <= 1'b0;
    end
  end
endmodule

// File: rtl/lta_checker.sv
module lta_checker #(
  parameter int DW      = 8,
  parameter int TRL_LEN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_kind,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_kind,
  input logic [DW-1:0] out_data,
  input logic          in_trl,
  input logic [DW-1:0] acc_par,
  input logic          acc_err
);
  logic [4:0] tcount;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcount <= '0;
    else if (out_valid && out_ready && out_kind == 2'd2) tcount <= '0;
    else if (out_valid && out_ready && in_trl) tcount <= tcount + 5'd1;
  end

  // R2: end marker leaves only after a full trailer
  p_trailer_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == 2'd2) |-> (tcount == 5'(TRL_LEN)));

  // R5: start marker clears parity and error flag
  p_clear_on_soe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == 2'd1) |=> (acc_par == '0 && !acc_err));

  // R6: no intake while trailer bytes are sent
  p_no_intake_in_trailer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_trl |-> !in_ready);

  // R7: output beat held under back-pressure
  p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind)));

  // R9: idle right after reset
  p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid || $past(in_valid));
endmodule

bind link_trailer_appender lta_checker #(.DW(DW), .TRL_LEN(TRL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .out_valid(out_valid), .out_ready(out_ready),
  .out_kind(out_kind), .out_data(out_data), .in_trl(in_trl),
  .acc_par(acc_par), .acc_err(acc_err)
);

// File: tb/tb_link_trailer_appender.sv
module tb_link_trailer_appender;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct packed {
    logic [1:0] k;
    logic [7:0] d;
    logic [3:0] tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic       in_valid [2];
  logic       in_ready [2];
  logic [1:0] in_kind  [2];
  logic [7:0] in_data  [2];
  logic       in_err   [2];
  logic       out_valid[2];
  logic       out_ready[2];
  logic [1:0] out_kind [2];
  logic [7:0] out_data [2];

  item_t q0[$];
  item_t q1[$];
  int    checks = 0;
  int    errors = 0;
  bit    bp[2];
  bit    done = 1'b0;

  link_trailer_appender #(.DW(8), .WIDE(1'b0), .CARD_ID(2'd1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid[0]), .in_ready(in_ready[0]),
    .in_kind(in_kind[0]), .in_data(in_data[0]), .in_rx_err(in_err[0]),
    .out_valid(out_valid[0]), .out_ready(out_ready[0]),
    .out_kind(out_kind[0]), .out_data(out_data[0])
  );

  link_trailer_appender #(.DW(8), .WIDE(1'b1), .CARD_ID(2'd2)) dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid[1]), .in_ready(in_ready[1]),
    .in_kind(in_kind[1]), .in_data(in_data[1]), .in_rx_err(in_err[1]),
    .out_valid(out_valid[1]), .out_ready(out_ready[1]),
    .out_kind(out_kind[1]), .out_data(out_data[1])
  );

  task automatic push_exp(input int s, input logic [1:0] k, input logic [7:0] d,
                          input int tag);
    item_t it;
    it.k = k; it.d = d; it.tag = 4'(tag);
    if (s == 0) q0.push_back(it);
    else q1.push_back(it);
  endtask

  task automatic put(input int s, input logic [1:0] k, input logic [7:0] d,
                     input logic e, output int waits);
    @(negedge clk);
    in_valid[s] = 1'b1; in_kind[s] = k; in_data[s] = d; in_err[s] = e;
    waits = 0;
    #0.5;
    while (!in_ready[s]) begin
      waits++;
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    #0.1;
    in_valid[s] = 1'b0;
    in_err[s]   = 1'b0;
  endtask

  // scoreboard-driven event: expected items queued before each beat is driven
  task automatic send_event(input int s, input int n, input int seed,
                            input int err_pos, input logic soe_err,
                            input bit check_stall);
    logic [7:0] b[$];
    logic [7:0] par = 8'h00;
    logic       er  = 1'b0;
    int         nf, w, tl;
    logic [7:0] h0, h1;
    for (int i = 0; i < n; i++) begin
      b.push_back(8'(seed * 29 + i * 11 + 3));
      par = par ^ b[i];
      if (i == err_pos) er = 1'b1;
    end
    nf = (s == 0) ? n : ((n > 2) ? n - 2 : 0);
    tl = (s == 0) ? 2 : 16;
    push_exp(s, 2'd1, 8'h00, 1);                       // R1 start marker
    put(s, 2'd1, 8'h00, soe_err, w);                   // R5 strobe on marker ignored
    for (int i = 0; i < n; i++) begin
      if (i < nf) push_exp(s, 2'd0, b[i], 1);          // R1 / R8 forwarded data
      put(s, 2'd0, b[i], (i == err_pos), w);
    end
    if (s == 1) begin                                  // R8 held upstream trailer
      h0 = (n >= 2) ? b[n-2] : 8'h00;
      h1 = (n >= 1) ? b[n-1] : 8'h00;
      push_exp(s, 2'd0, h0, 8);
      push_exp(s, 2'd0, h1, 8);
      for (int i = 2; i < 14; i++) push_exp(s, 2'd0, 8'h00, 8);
    end
    push_exp(s, 2'd0, par, 3);                         // R3 parity
    push_exp(s, 2'd0, {er, 5'b0, (s == 0) ? 2'd1 : 2'd2}, 4);  // R4 status
    push_exp(s, 2'd2, 8'h00, 2);                       // R2 end after trailer
    put(s, 2'd2, 8'h00, 1'b1, w);
    if (check_stall) begin                             // R6 stall length
      checks++;
      if (w != tl + 1) begin
        errors++;
        $display("FAIL R6 dut%0d end-marker stall: actual %0d expected %0d", s, w, tl + 1);
      end
    end
  endtask

  // back-pressure source
  initial begin
    forever begin
      @(negedge clk);
      for (int s = 0; s < 2; s++)
        out_ready[s] = bp[s] ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // monitor: compares every accepted output beat against the queue (R7 under bp)
  initial begin : monitor
    item_t e;
    forever begin
      @(negedge clk);
      #1;
      for (int s = 0; s < 2; s++) begin
        if (rst_n && out_valid[s] && out_ready[s]) begin
          checks++;
          if ((s == 0 && q0.size() == 0) || (s == 1 && q1.size() == 0)) begin
            errors++;
            $display("FAIL R2 dut%0d unexpected beat: actual kind %0d data %02h expected none",
                     s, out_kind[s], out_data[s]);
          end else begin
            e = (s == 0) ? q0.pop_front() : q1.pop_front();
            if (out_kind[s] !== e.k || out_data[s] !== e.d) begin
              errors++;
              $display("FAIL R%0d dut%0d beat: actual kind %0d data %02h expected kind %0d data %02h",
                       e.tag, s, out_kind[s], out_data[s], e.k, e.d);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int s = 0; s < 2; s++) begin
      in_valid[s] = 1'b0; in_kind[s] = 2'd0; in_data[s] = 8'h00;
      in_err[s] = 1'b0; out_ready[s] = 1'b1; bp[s] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    for (int s = 0; s < 2; s++) begin                  // R9 reset state
      checks++;
      if (out_valid[s] !== 1'b0) begin
        errors++;
        $display("FAIL R9 dut%0d out_valid after reset: actual %b expected 0", s, out_valid[s]);
      end
    end
    // short variant, free flowing
    send_event(0, 5, 1, -1, 1'b0, 1'b1);               // R1 R3
    send_event(0, 6, 2, 3, 1'b0, 1'b1);                // R4 error on middle byte
    send_event(0, 0, 3, -1, 1'b0, 1'b1);               // R3 empty event parity 0
    send_event(0, 4, 4, -1, 1'b1, 1'b1);               // R5 cleared, start strobe ignored
    // short variant, random back-pressure
    bp[0] = 1'b1;
    send_event(0, 20, 5, 7, 1'b0, 1'b0);               // R7
    send_event(0, 3, 6, -1, 1'b0, 1'b0);
    bp[0] = 1'b0;
    // wide variant
    send_event(1, 5, 7, -1, 1'b0, 1'b1);               // R8
    send_event(1, 1, 8, -1, 1'b0, 1'b1);               // R8 zero-fill one missing byte
    send_event(1, 0, 9, -1, 1'b0, 1'b1);               // R8 zero-fill both
    send_event(1, 2, 10, 1, 1'b0, 1'b1);               // R4 R8 exactly two bytes
    send_event(1, 3, 11, -1, 1'b1, 1'b1);              // R5
    bp[1] = 1'b1;
    send_event(1, 18, 12, 16, 1'b0, 1'b0);             // R7 R8 under back-pressure
    bp[1] = 1'b0;
    for (int i = 0; i < 300 && (q0.size() + q1.size()) != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (q0.size() + q1.size() != 0) begin
      errors++;
      $display("FAIL R2 missing output beats: actual %0d pending expected 0", q0.size() + q1.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule